// File: doc/BRIEF.md
# Card Link Bit Framer

This block frames byte data for a contactless card link at the bit level, in both directions. On the transmit side a byte source hands over one frame as a valid/ready stream. The framer puts a single start bit on the line, then each byte least significant bit first followed by an odd-parity bit, and closes the frame with a 16-bit CRC sent as two parity-protected bytes. Bits leave one per strobe: the transmitter emits a bit only in a cycle where the bit-timing input `bit_en` is high, and marks that bit with `tx_stb`.

The receive side takes one bit per `rx_stb` cycle and a frame-end pulse `rx_end` from the line decoder. It rebuilds the bytes, checks odd parity on each, checks the CRC by its residue, and rejects frames longer than 163 bits. At frame end it pulses `rx_done` together with three error flags. A clean frame is then handed to the sink as a valid/ready byte stream, without the CRC bytes. A frame with any error delivers no bytes.

Back-pressure rules: the source must hold `s_valid`, `s_data` and `s_last` stable until the byte is accepted. When the source falls behind, the transmitter pauses between bytes and emits no strobes; no bit is lost. The sink may hold `m_ready` low for any time. While the received frame is being handed out, line strobes are ignored, so the sink must drain a frame before the next one starts.

Top module: `card_bit_framer`

## Requirements
- R1: A frame in either direction starts with exactly one start bit of value 1. The transmitter emits it as the first bit of every frame. An idle receiver starts a frame only on a strobed 1 and ignores strobed 0 bits.
- R2: Each byte goes on the line as 8 bits, least significant bit first. Bytes go out in the order they were accepted, so the first (lowest-addressed) byte is sent first.
- R3: Every byte, data or CRC, is followed by one parity bit chosen so that the 9 bits hold an odd number of ones.
- R4: The CRC uses x^16+x^12+x^5+1 processed least significant bit first (reflected constant 0x8408), with preset 0x6363 and no final inversion. It covers the data bytes, and its low byte is sent before its high byte. Data 0x00 0x00 gives the CRC bytes 0xA0 0x1E, and data 0x50 0x00 gives 0x57 0xCD.
- R5: A byte is accepted in a cycle where `s_valid` and `s_ready` are both high. `s_ready` stays low from the acceptance of a frame's last byte (`s_last` high) until the frame's final bit. If the next byte is late, the transmitter emits no strobe until that byte arrives, and the bit sequence is unchanged.
- R6: The 16th data byte of a frame closes the frame even when `s_last` is low, so a transmitted frame never exceeds 163 bits.
- R7: `tx_stb` is high only in cycles where `bit_en` is high, and it marks exactly one bit on `tx_bit`.
- R8: On the receive side, a parity mismatch on any byte, or a trailing group of 1 to 8 bits that does not complete a byte, raises `rx_par_err` at `rx_done`, and the frame's bytes are withheld.
- R9: The receiver runs the CRC over every received byte, CRC bytes included. A nonzero residue, or a frame of fewer than three bytes, raises `rx_crc_err`, and the bytes are withheld.
- R10: A 164th bit within one frame raises `rx_ovf` at the next `rx_end`, with the parity and CRC flags low and no bytes delivered.
- R11: A clean frame's data bytes (all received bytes except the last two) are handed out in order on `m_data`, with `m_last` marking the final one. `m_valid`, `m_data` and `m_last` hold steady while `m_ready` is low, and `m_valid` is never high while an error flag is set.
- R12: `rx_done` is a one-cycle pulse for each `rx_end` that arrives while a frame is being received. An `rx_end` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Transmit bit-timing strobe, one cycle per bit slot |
| s_valid | input | 1 | Transmit byte valid |
| s_ready | output | 1 | Transmit byte accepted when high with `s_valid` |
| s_data | input | 8 | Transmit byte |
| s_last | input | 1 | Marks the last data byte of the frame |
| tx_bit | output | 1 | Transmitted bit value, meaningful when `tx_stb` is high |
| tx_stb | output | 1 | One transmitted bit in this cycle |
| tx_busy | output | 1 | A frame is in transmission |
| rx_bit | input | 1 | Received bit value |
| rx_stb | input | 1 | One received bit in this cycle |
| rx_end | input | 1 | End of the received frame |
| m_valid | output | 1 | Received data byte valid |
| m_ready | input | 1 | Sink takes the byte |
| m_data | output | 8 | Received data byte |
| m_last | output | 1 | Final data byte of the frame |
| rx_done | output | 1 | One-cycle pulse at the end of a received frame |
| rx_par_err | output | 1 | Parity or incomplete-byte error of the last frame |
| rx_crc_err | output | 1 | CRC error of the last frame |
| rx_ovf | output | 1 | Length overflow of the last frame |

## Verification
The assertions take two things for granted about the inputs. The byte source keeps `s_valid`, `s_data` and `s_last` unchanged while a byte waits for `s_ready`. The line decoder never raises `rx_end` in the same cycle as `rx_stb`. The stimulus respects both. Its driver tasks drive a byte and hold it until the handshake is seen. Received bits are spaced two cycles apart, and the frame-end pulse is given in its own cycle after the last bit. Back-pressure on the output stream comes from a fixed `m_ready` pattern that is independent of the design.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

  localparam logic [15:0] CBF_POLY_REFL = 16'h8408;

  typedef enum logic [1:0] {T_IDLE, T_START, T_LOAD, T_SHIFT} tx_state_e;
  typedef enum logic [1:0] {PH_DATA, PH_CRC_LO, PH_CRC_HI}    tx_phase_e;
  typedef enum logic [1:0] {R_IDLE, R_RECV, R_SKIP, R_DRAIN}  rx_state_e;

  // One byte through the reflected CRC, bit 0 of the byte first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CBF_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/cbf_tx.sv
module cbf_tx #(
  parameter int          MAX_BYTES  = 16,
  parameter logic [15:0] CRC_PRESET = 16'h6363
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       tx_bit,
  output logic       tx_stb,
  output logic       tx_busy
);
  import cbf_pkg::*;

  localparam int CNT_W      = $clog2(MAX_BYTES + 1);
  localparam int FRAME_BITS = 1 + (MAX_BYTES + 2) * 9;
  localparam int FB_W       = $clog2(FRAME_BITS + 1);

  tx_state_e        state;
  tx_phase_e        phase;
  logic [7:0]       hold_q;
  logic             hold_full, hold_last, got_last, cur_last;
  logic [CNT_W-1:0] acc_cnt;
  logic [7:0]       sh;
  logic [3:0]       bit_idx;
  logic             par_q;
  logic [15:0]      crc_q;
  logic [FB_W-1:0]  fbits;

  logic accept, take, emit, frame_end, closes;

  assign s_ready   = !hold_full && !got_last;
  assign accept    = s_valid && s_ready;
  assign take      = (state == T_LOAD) && (phase == PH_DATA) && hold_full;
  assign emit      = bit_en && ((state == T_START) || (state == T_SHIFT));
  assign frame_end = emit && (state == T_SHIFT) && (bit_idx == 4'd8) && (phase == PH_CRC_HI);
  assign closes    = s_last || (acc_cnt == CNT_W'(MAX_BYTES - 1));

  assign tx_stb  = emit;
  assign tx_bit  = (state == T_START) ? 1'b1 : ((bit_idx == 4'd8) ? par_q : sh[0]);
  assign tx_busy = (state != T_IDLE);

  // One-byte holding register between the source and the serializer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      hold_last <= 1'b0;
      got_last  <= 1'b0;
      acc_cnt   <= '0;
    end else begin
      if (accept) begin
        hold_q    <= s_data;
        hold_full <= 1'b1;
        hold_last <= closes;
        got_last  <= closes;
        acc_cnt   <= acc_cnt + 1'b1;
      end else if (take) begin
        hold_full <= 1'b0;
      end
      if (frame_end) begin
        got_last <= 1'b0;
        acc_cnt  <= '0;
      end
    end
  end

  // Serializer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= T_IDLE;
      phase    <= PH_DATA;
      sh       <= '0;
      bit_idx  <= '0;
      par_q    <= 1'b1;
      cur_last <= 1'b0;
      crc_q    <= CRC_PRESET;
    end else begin
      unique case (state)
        T_IDLE: if (hold_full) begin
          state <= T_START;
          phase <= PH_DATA;
          crc_q <= CRC_PRESET;
        end
        T_START: if (bit_en) state <= T_LOAD;
        T_LOAD: begin
          if (phase == PH_DATA) begin
            if (hold_full) begin
              sh       <= hold_q;
              cur_last <= hold_last;
              crc_q    <= crc16_byte(crc_q, hold_q);
              bit_idx  <= '0;
              par_q    <= 1'b1;
              state    <= T_SHIFT;
            end
          end else begin
            sh      <= (phase == PH_CRC_LO) ? crc_q[7:0] : crc_q[15:8];
            bit_idx <= '0;
            par_q   <= 1'b1;
            state   <= T_SHIFT;
          end
        end
        T_SHIFT: if (bit_en) begin
          if (bit_idx != 4'd8) begin
            sh      <= sh >> 1;
            par_q   <= par_q ^ sh[0];
            bit_idx <= bit_idx + 1'b1;
          end else begin
            unique case (phase)
              PH_DATA: begin
                if (cur_last) phase <= PH_CRC_LO;
                state <= T_LOAD;
              end
              PH_CRC_LO: begin
                phase <= PH_CRC_HI;
                state <= T_LOAD;
              end
              default: state <= T_IDLE;
            endcase
          end
        end
        default: state <= T_IDLE;
      endcase
    end
  end

  // Bits emitted in the current frame, for the length check below.
  always_ff @(posedge clk) begin
    if (!rst_n || state == T_IDLE) fbits <= '0;
    else if (emit)                 fbits <= fbits + 1'b1;
  end

  assert_stb_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |-> bit_en);

  assert_frame_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |-> (fbits < FB_W'(FRAME_BITS)));

  assert_close_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last) |=> !s_ready);

  assert_src_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> (s_valid && $stable(s_data) && $stable(s_last)));

endmodule

// File: rtl/cbf_rx.sv
module cbf_rx #(
  parameter int          MAX_BYTES  = 16,
  parameter logic [15:0] CRC_PRESET = 16'h6363
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic       rx_stb,
  input  logic       rx_end,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_last,
  output logic       rx_done,
  output logic       rx_par_err,
  output logic       rx_crc_err,
  output logic       rx_ovf
);
  import cbf_pkg::*;

  localparam int BUF_N      = MAX_BYTES + 2;
  localparam int IDX_W      = $clog2(BUF_N + 1);
  localparam int FRAME_BITS = 1 + BUF_N * 9;
  localparam int FB_W       = $clog2(FRAME_BITS + 1);

  rx_state_e        state;
  logic [7:0]       sh;
  logic [3:0]       bit_idx;
  logic             par_acc, par_seen;
  logic [15:0]      crc_q;
  logic [FB_W-1:0]  nbits;
  logic [IDX_W-1:0] nbytes, rd_ptr, n_out;
  logic [7:0]       buf_q [BUF_N];

  logic take_bit, byte_done, too_long, perr, cerr;

  assign too_long  = (nbits == FB_W'(FRAME_BITS));
  assign take_bit  = (state == R_RECV) && !rx_end && rx_stb && !too_long;
  assign byte_done = take_bit && (bit_idx == 4'd8);
  assign perr      = par_seen || (bit_idx != 4'd0);
  assign cerr      = (nbytes < IDX_W'(3)) || (crc_q != 16'h0000);

  assign m_valid = (state == R_DRAIN);
  assign m_data  = buf_q[rd_ptr];
  assign m_last  = ((rd_ptr + IDX_W'(1)) == n_out);

  always_ff @(posedge clk) begin
    if (byte_done && (nbytes < IDX_W'(BUF_N))) buf_q[nbytes] <= sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= R_IDLE;
      sh         <= '0;
      bit_idx    <= '0;
      par_acc    <= 1'b0;
      par_seen   <= 1'b0;
      crc_q      <= CRC_PRESET;
      nbits      <= '0;
      nbytes     <= '0;
      rd_ptr     <= '0;
      n_out      <= '0;
      rx_done    <= 1'b0;
      rx_par_err <= 1'b0;
      rx_crc_err <= 1'b0;
      rx_ovf     <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      unique case (state)
        R_IDLE: if (rx_stb && rx_bit) begin
          state    <= R_RECV;
          bit_idx  <= '0;
          par_acc  <= 1'b0;
          par_seen <= 1'b0;
          crc_q    <= CRC_PRESET;
          nbits    <= FB_W'(1);
          nbytes   <= '0;
        end
        R_RECV: begin
          if (rx_end) begin
            rx_done    <= 1'b1;
            rx_par_err <= perr;
            rx_crc_err <= cerr;
            rx_ovf     <= 1'b0;
            rd_ptr     <= '0;
            n_out      <= nbytes - IDX_W'(2);
            state      <= (perr || cerr) ? R_IDLE : R_DRAIN;
          end else if (rx_stb) begin
            if (too_long) begin
              state <= R_SKIP;
            end else begin
              nbits <= nbits + 1'b1;
              if (bit_idx != 4'd8) begin
                sh      <= {rx_bit, sh[7:1]};
                par_acc <= par_acc ^ rx_bit;
                bit_idx <= bit_idx + 1'b1;
              end else begin
                if (!(par_acc ^ rx_bit)) par_seen <= 1'b1;
                crc_q   <= crc16_byte(crc_q, sh);
                nbytes  <= nbytes + 1'b1;
                bit_idx <= '0;
                par_acc <= 1'b0;
              end
            end
          end
        end
        R_SKIP: if (rx_end) begin
          rx_done    <= 1'b1;
          rx_par_err <= 1'b0;
          rx_crc_err <= 1'b0;
          rx_ovf     <= 1'b1;
          state      <= R_IDLE;
        end
        R_DRAIN: if (m_ready) begin
          rd_ptr <= rd_ptr + 1'b1;
          if (m_last) state <= R_IDLE;
        end
        default: state <= R_IDLE;
      endcase
    end
  end

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  assert_end_alone_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |-> !rx_stb);

  assert_hold_stream_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  assert_clean_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !(rx_par_err || rx_crc_err || rx_ovf));

endmodule

// File: rtl/card_bit_framer.sv
module card_bit_framer #(
  parameter int          MAX_BYTES  = 16,
  parameter logic [15:0] CRC_PRESET = 16'h6363
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       tx_bit,
  output logic       tx_stb,
  output logic       tx_busy,
  input  logic       rx_bit,
  input  logic       rx_stb,
  input  logic       rx_end,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_last,
  output logic       rx_done,
  output logic       rx_par_err,
  output logic       rx_crc_err,
  output logic       rx_ovf
);

  cbf_tx #(.MAX_BYTES(MAX_BYTES), .CRC_PRESET(CRC_PRESET)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .s_last  (s_last),
    .tx_bit  (tx_bit),
    .tx_stb  (tx_stb),
    .tx_busy (tx_busy)
  );

  cbf_rx #(.MAX_BYTES(MAX_BYTES), .CRC_PRESET(CRC_PRESET)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_bit     (rx_bit),
    .rx_stb     (rx_stb),
    .rx_end     (rx_end),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_data     (m_data),
    .m_last     (m_last),
    .rx_done    (rx_done),
    .rx_par_err (rx_par_err),
    .rx_crc_err (rx_crc_err),
    .rx_ovf     (rx_ovf)
  );

endmodule

// File: tb/card_bit_framer_tb.sv
module card_bit_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXF_BITS  = 163;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, tx_bit, tx_stb, tx_busy;
  logic rx_bit = 1'b0, rx_stb = 1'b0, rx_end = 1'b0;
  logic m_ready = 1'b0;
  logic m_valid, m_last, rx_done, rx_par_err, rx_crc_err, rx_ovf;
  logic [7:0] m_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic       txq [$];
  logic [8:0] rxq [$];
  logic [2:0] stq [$];
  logic [7:0] frame_buf [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  card_bit_framer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .tx_bit(tx_bit), .tx_stb(tx_stb), .tx_busy(tx_busy),
    .rx_bit(rx_bit), .rx_stb(rx_stb), .rx_end(rx_end),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .rx_done(rx_done), .rx_par_err(rx_par_err), .rx_crc_err(rx_crc_err), .rx_ovf(rx_ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Byte-wise form of the link CRC, written independently of the bit loop.
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [7:0] ch;
    ch = d ^ c[7:0];
    ch = ch ^ (ch << 4);
    return (c >> 8) ^ ({8'h00, ch} << 8) ^ ({8'h00, ch} << 3) ^ ({8'h00, ch} >> 4);
  endfunction

  // Free-running stimulus: bit slots every 4 cycles, sink ready 2 of 3 cycles.
  int en_div = 0;
  always begin
    @(posedge clk); #1;
    en_div++;
    bit_en  = (en_div % 4 == 0);
    m_ready = (en_div % 3 != 0);
  end

  // Monitors.
  always @(negedge clk) if (rst_n) begin
    if (tx_stb) begin
      if (txq.size() == 0) chk(1'b0, "R1/R2 unexpected tx bit", tx_bit, 0);
      else begin
        automatic logic e = txq.pop_front();
        chk(tx_bit == e, "R2/R3/R4 tx bit", tx_bit, e);
      end
    end
    if (m_valid && m_ready) begin
      if (rxq.size() == 0) chk(1'b0, "R11 unexpected rx byte", m_data, 0);
      else begin
        automatic logic [8:0] e = rxq.pop_front();
        chk({m_last, m_data} == e, "R11 rx byte", {m_last, m_data}, e);
      end
    end
    if (rx_done) begin
      if (stq.size() == 0) chk(1'b0, "R12 unexpected rx_done", 1, 0);
      else begin
        automatic logic [2:0] e = stq.pop_front();
        chk({rx_par_err, rx_crc_err, rx_ovf} == e, "R8/R9/R10 status",
            {rx_par_err, rx_crc_err, rx_ovf}, e);
      end
    end
  end

  task automatic push_byte(input logic [7:0] d, input logic last);
    @(posedge clk); #1;
    s_valid = 1'b1; s_data = d; s_last = last;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    @(posedge clk); #1;
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic tx_frame(input int n, input int sent_n, input bit with_last, input int gap);
    logic [15:0] c = 16'h6363;
    logic [7:0]  b;
    txq.push_back(1'b1);
    for (int i = 0; i < sent_n; i++) begin
      b = frame_buf[i];
      for (int k = 0; k < 8; k++) txq.push_back(b[k]);
      txq.push_back(~^b);
      c = ref_crc(c, b);
    end
    for (int j = 0; j < 2; j++) begin
      b = (j == 0) ? c[7:0] : c[15:8];
      for (int k = 0; k < 8; k++) txq.push_back(b[k]);
      txq.push_back(~^b);
    end
    for (int i = 0; i < n; i++) begin
      push_byte(frame_buf[i], with_last && (i == n - 1));
      repeat (gap) @(posedge clk);
    end
  endtask

  task automatic wait_tx();
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk);
      if (txq.size() == 0 && !tx_busy) break;
    end
    chk(txq.size() == 0 && !tx_busy, "R5 tx frame complete", txq.size(), 0);
  endtask

  task automatic rx_send(input logic b);
    @(posedge clk); #1; rx_stb = 1'b1; rx_bit = b;
    @(posedge clk); #1; rx_stb = 1'b0; rx_bit = 1'b0;
  endtask

  task automatic rx_pulse_end();
    @(posedge clk); #1; rx_end = 1'b1;
    @(posedge clk); #1; rx_end = 1'b0;
  endtask

  task automatic rx_frame(input int n, input int bad_par, input bit bad_crc,
                          input int extra, input bit add_crc);
    logic [7:0]  all [0:31];
    logic [15:0] c = 16'h6363;
    int tot, nbits_f;
    bit ovf, perr, cerr;
    for (int i = 0; i < n; i++) begin
      all[i] = frame_buf[i];
      c = ref_crc(c, frame_buf[i]);
    end
    tot = n;
    if (add_crc) begin
      all[n] = c[7:0] ^ {7'b0, bad_crc};
      all[n+1] = c[15:8];
      tot = n + 2;
    end
    nbits_f = 1 + tot * 9 + extra;
    ovf  = nbits_f > MAXF_BITS;
    perr = !ovf && (bad_par >= 0 || extra > 0);
    cerr = !ovf && (tot < 3 || bad_crc);
    stq.push_back({perr, cerr, ovf});
    if (!ovf && !perr && !cerr)
      for (int i = 0; i < tot - 2; i++) rxq.push_back({i == tot - 3, all[i]});
    rx_send(1'b1);
    for (int i = 0; i < tot; i++) begin
      for (int k = 0; k < 8; k++) rx_send(all[i][k]);
      rx_send((~^all[i]) ^ (i == bad_par));
    end
    for (int k = 0; k < extra; k++) rx_send(1'b1);
    rx_pulse_end();
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      if (stq.size() == 0 && rxq.size() == 0 && !m_valid) break;
    end
    chk(stq.size() == 0 && rxq.size() == 0, "R11/R12 rx frame drained",
        stq.size() + rxq.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R5 reset s_ready", s_ready, 1);
    chk(!tx_stb && !tx_busy, "R7 reset tx idle", {tx_stb, tx_busy}, 0);
    chk(!m_valid && !rx_done, "R12 reset rx idle", {m_valid, rx_done}, 0);

    // R4: bench CRC model against the fixed vectors.
    chk(ref_crc(ref_crc(16'h6363, 8'h00), 8'h00) == 16'h1EA0, "R4 vector 00 00",
        ref_crc(ref_crc(16'h6363, 8'h00), 8'h00), 16'h1EA0);
    chk(ref_crc(ref_crc(16'h6363, 8'h50), 8'h00) == 16'hCD57, "R4 vector 50 00",
        ref_crc(ref_crc(16'h6363, 8'h50), 8'h00), 16'hCD57);

    // TX R1 R2 R3 R4: two zero bytes, then a last-byte close check (R5).
    frame_buf[0] = 8'h00; frame_buf[1] = 8'h00;
    tx_frame(2, 2, 1'b1, 0);
    @(negedge clk);
    chk(!s_ready, "R5 ready low after last byte", s_ready, 0);
    wait_tx();
    frame_buf[0] = 8'h50; frame_buf[1] = 8'h00;
    tx_frame(2, 2, 1'b1, 0);
    wait_tx();
    // R5: slow source, serializer stalls between bytes.
    frame_buf[0] = 8'hA5; frame_buf[1] = 8'h3C; frame_buf[2] = 8'h01; frame_buf[3] = 8'h80;
    tx_frame(4, 4, 1'b1, 90);
    wait_tx();
    frame_buf[0] = 8'hFF;
    tx_frame(1, 1, 1'b1, 0);
    wait_tx();
    // R6: sixteen bytes without s_last close the frame.
    for (int i = 0; i < 16; i++) frame_buf[i] = 8'(i * 37 + 5);
    tx_frame(16, 16, 1'b0, 0);
    @(negedge clk);
    chk(!s_ready, "R6 frame closed at 16 bytes", s_ready, 0);
    wait_tx();
    @(negedge clk);
    chk(s_ready, "R5 ready back after frame", s_ready, 1);

    // RX R1: stray zero strobe and idle rx_end (R12) are ignored.
    rx_send(1'b0);
    rx_pulse_end();
    repeat (3) @(negedge clk);
    chk(stq.size() == 0 && !rx_done && !m_valid, "R12 idle end ignored", rx_done, 0);
    frame_buf[0] = 8'h12; frame_buf[1] = 8'h34; frame_buf[2] = 8'hF0;
    rx_frame(3, -1, 1'b0, 0, 1'b1);
    rx_frame(3, 1, 1'b0, 0, 1'b1);   // R8 parity
    rx_frame(3, -1, 1'b1, 0, 1'b1);  // R9 crc
    rx_frame(3, -1, 1'b0, 3, 1'b1);  // R8 partial byte
    rx_frame(1, -1, 1'b0, 0, 1'b0);  // R9 short frame
    frame_buf[0] = 8'h5A;
    rx_frame(1, -1, 1'b0, 0, 1'b1);  // single data byte
    for (int i = 0; i < 17; i++) frame_buf[i] = 8'(i * 19 + 3);
    rx_frame(16, -1, 1'b0, 0, 1'b1); // 163 bits, accepted
    rx_frame(17, -1, 1'b0, 0, 1'b1); // R10 overflow
    repeat (5) @(negedge clk);
    chk(!m_valid, "R10 no bytes after overflow", m_valid, 0);
    report();
  end

endmodule